// File: doc/BRIEF.md
# Time-Shared Multiphase PWM Sequencer

This block drives the top and bottom gate signals of every phase of an interleaved buck converter with up to `MAX_PH` phases. It does not give each edge of each phase its own comparator. Four timing channels do all the work, one for each kind of edge: top rising, top falling, bottom rising and bottom falling. Each channel compares one free-running period counter with the time of its next pending event. When the two match, the channel emits a one-cycle pulse and moves on to the same kind of event in the next phase. A per-channel phase pointer, decoded to one-hot, steers that pulse to the set or clear input of the matching output latch.

Software supplies a table of event times, indexed by edge kind and by phase. It also supplies the period in clocks, the number of active phases and an enable. The counter restarts at every period origin, and the top output of phase 0 rises at that origin. The programmed period therefore sets the switching frequency directly. Resolution is one clock. A guard holds both outputs of a phase low if the event data would turn both on together. A separate flag reports an event time that the time-sharing order cannot reach.

Top module: `mph_pwm_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every gate output and both error flags are 0 from the next cycle on.
- R2: The period counter counts 0 to `period`-1 (period ≥ 2) and then wraps. The cycle in which it is 0 is the period origin. The top rising time of phase 0 is fixed at 0, whatever its table entry holds.
- R3: Table layout: `ev_time[k][p]` is the time of edge kind k for phase p, with k=0 top rise, k=1 top fall, k=2 bottom rise and k=3 bottom fall. Without overlap, an output is high in exactly the cycles whose count c meets rise < c ≤ fall. An event at count t therefore takes effect one cycle later.
- R4: Each channel serves the phases in the order 0..N-1 and moves to the next phase only after the current event fires. Phases numbered N or higher stay low, and their table entries have no effect. An N of 0 acts as 1, and an N above `MAX_PH` acts as `MAX_PH`.
- R5: A new `num_phases` or `period` takes effect only at the next period origin. The period already running completes with the old values.
- R6: At the end of every period all four channels return to phase 0, so a skipped event does not carry into the next period.
- R7: While the top and bottom latches of one phase are both set, both outputs of that phase are driven low. `overlap_err` then goes to 1 and stays 1 while enabled. Top and bottom of one phase are never both high.
- R8: When a channel fires and the next phase's time for that kind is not later than the current count, `miss_err` goes to 1 and stays 1 while enabled. The skipped event and all later events of that kind in the period do not occur.
- R9: While `enable` is low at an edge, all outputs, pointers and flags are cleared from the next cycle on. After `enable` is raised, the first cycle is a period origin with phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run when high, halt and clear when low |
| period | input | CW | Switching period in clocks |
| num_phases | input | PW | Active phase count N |
| ev_time | input | 4×MAX_PH×CW | Event times by edge kind and phase |
| top_o | output | MAX_PH | Top-switch gate drive per phase |
| bot_o | output | MAX_PH | Bottom-switch gate drive per phase |
| overlap_err | output | 1 | Sticky overlap-guard flag |
| miss_err | output | 1 | Sticky missed-event flag |

## Verification
Some properties are checked on every cycle. Top and bottom of a phase are never both high. A halt clears the outputs and flags one cycle later. Each steering decode is at most one-hot, and each phase pointer stays below the latched phase count. Both error flags are sticky.

Other behaviour can only be shown by the bench's scenarios against waveforms it computes itself:
- the exact cycle of each edge;
- ignoring the phase-0 top rising entry;
- deferring a phase-count change to the next origin;
- skipping events after a miss, and resyncing at the period end.

// File: rtl/mph_pkg.sv
// Package mph_pkg
// Shared constants for the multiphase sequencer. The edge-kind
// numbering is the first index of the event-time table, so the order
// below is part of the interface.
package mph_pkg;
    localparam int NUM_KINDS = 4;
    typedef enum logic [1:0] {
        KIND_TOP_RISE = 2'd0,
        KIND_TOP_FALL = 2'd1,
        KIND_BOT_RISE = 2'd2,
        KIND_BOT_FALL = 2'd3
    } edge_kind_e;
endpackage

// File: rtl/mph_period_timer.sv
// Module mph_period_timer
// Free-running period counter. It also latches the period and the
// clamped phase count, taking new values only while halted or on the
// last cycle of a period. Assumes period >= 2.
module mph_period_timer #(
    parameter int MAX_PH = 4,
    parameter int CW     = 8,
    parameter int PW     = $clog2(MAX_PH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] period,
    input  logic [PW-1:0] num_phases,
    output logic          running,
    output logic          last,
    output logic [CW-1:0] cnt,
    output logic [PW-1:0] n_act
);
    logic [CW-1:0] period_q;
    logic [PW-1:0] n_clamped;

    // Clamp the requested phase count into 1..MAX_PH.
    always_comb begin
        if (num_phases == '0)
            n_clamped = PW'(1);
        else if (num_phases > PW'(MAX_PH))
            n_clamped = PW'(MAX_PH);
        else
            n_clamped = num_phases;
    end

    assign last = running && (cnt == period_q - 1'b1);

    // Advance the counter and latch the configuration at safe points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            cnt      <= '0;
            period_q <= '0;
            n_act    <= PW'(1);
        end else if (!enable) begin
            running  <= 1'b0;
            cnt      <= '0;
            period_q <= period;
            n_act    <= n_clamped;
        end else if (!running) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (last) begin
            cnt      <= '0;
            period_q <= period;
            n_act    <= n_clamped;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mph_edge_channel.sv
// Module mph_edge_channel
// One shared timing channel for a single edge kind. It compares the
// period count with the armed time of the current phase, pulses `fire`
// on a match and arms the next phase's time on the same edge. It flags
// a miss when that next time is not later than the current count.
// Assumes event times rise with phase order inside one period.
module mph_edge_channel #(
    parameter int MAX_PH      = 4,
    parameter int CW          = 8,
    parameter int PW          = $clog2(MAX_PH + 1),
    parameter bit FORCE_ZERO0 = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     running,
    input  logic                     last,
    input  logic [CW-1:0]            cnt,
    input  logic [PW-1:0]            n_act,
    input  logic [MAX_PH-1:0][CW-1:0] times,
    output logic                     fire,
    output logic [PW-1:0]            ptr,
    output logic                     miss
);
    logic [CW-1:0] tgt;
    logic [PW-1:0] nxt;
    logic [CW-1:0] t_nxt;
    logic [CW-1:0] t_zero;

    // Pick the next phase index and the times it would arm.
    always_comb begin
        nxt    = (ptr == n_act - 1'b1) ? '0 : ptr + 1'b1;
        t_nxt  = '0;
        t_zero = times[0];
        for (int i = 0; i < MAX_PH; i++) begin
            if (nxt == PW'(i))
                t_nxt = times[i];
        end
        if (FORCE_ZERO0) begin
            t_zero = '0;
            if (nxt == '0)
                t_nxt = '0;
        end
    end

    assign fire = running && (cnt == tgt);
    assign miss = fire && !last && (nxt != '0) && (t_nxt <= cnt);

    // Hold, advance or resynchronise the phase pointer and armed time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            tgt <= '0;
        end else if (!enable || !running || last) begin
            ptr <= '0;
            tgt <= t_zero;
        end else if (fire) begin
            ptr <= nxt;
            tgt <= t_nxt;
        end
    end
endmodule

// File: rtl/mph_onehot_dec.sv
// Module mph_onehot_dec
// Decodes a phase pointer into a one-hot enable vector. An index at or
// above WIDTH yields all zeros.
module mph_onehot_dec #(
    parameter int WIDTH = 4,
    parameter int PW    = $clog2(WIDTH + 1)
) (
    input  logic [PW-1:0]    idx,
    output logic [WIDTH-1:0] oh
);
    // Compare the index against every position.
    always_comb begin
        for (int i = 0; i < WIDTH; i++)
            oh[i] = (idx == PW'(i));
    end
endmodule

// File: rtl/mph_gate_latch.sv
// Module mph_gate_latch
// Set/clear latches for one phase's top and bottom gate signals. When
// set and clear arrive together, clear wins. Everything is cleared
// while the block is halted.
module mph_gate_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_top,
    input  logic clr_top,
    input  logic set_bot,
    input  logic clr_bot,
    output logic top_raw,
    output logic bot_raw
);
    // Top-switch latch.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) top_raw <= 1'b0;
        else if (clr_top)      top_raw <= 1'b0;
        else if (set_top)      top_raw <= 1'b1;
    end

    // Bottom-switch latch.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) bot_raw <= 1'b0;
        else if (clr_bot)      bot_raw <= 1'b0;
        else if (set_bot)      bot_raw <= 1'b1;
    end
endmodule

// File: rtl/mph_pwm_seq.sv
// Module mph_pwm_seq (top)
// Multiphase gate-drive sequencer. Four shared edge channels fire
// against one period counter, and one-hot phase pointers route each
// pulse to a per-phase latch. A guard blocks top/bottom overlap.
// Assumes period >= 2 and that the event times of each kind rise with
// phase order and lie in 0..period-1.
module mph_pwm_seq
    import mph_pkg::*;
#(
    parameter int MAX_PH = 4,
    parameter int CW     = 8,
    parameter int PW     = $clog2(MAX_PH + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                enable,
    input  logic [CW-1:0]                       period,
    input  logic [PW-1:0]                       num_phases,
    input  logic [NUM_KINDS-1:0][MAX_PH-1:0][CW-1:0] ev_time,
    output logic [MAX_PH-1:0]                   top_o,
    output logic [MAX_PH-1:0]                   bot_o,
    output logic                                overlap_err,
    output logic                                miss_err
);
    logic                                 running;
    logic                                 last;
    logic [CW-1:0]                        cnt;
    logic [PW-1:0]                        n_act;
    logic [NUM_KINDS-1:0]                 fire;
    logic [NUM_KINDS-1:0]                 miss_v;
    logic [NUM_KINDS-1:0][PW-1:0]         ptr;
    logic [NUM_KINDS-1:0][MAX_PH-1:0]     dec_oh;
    logic [MAX_PH-1:0]                    top_raw;
    logic [MAX_PH-1:0]                    bot_raw;

    mph_period_timer #(.MAX_PH(MAX_PH), .CW(CW), .PW(PW)) u_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
        .num_phases(num_phases), .running(running), .last(last),
        .cnt(cnt), .n_act(n_act)
    );

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        mph_edge_channel #(
            .MAX_PH(MAX_PH), .CW(CW), .PW(PW),
            .FORCE_ZERO0(k == int'(KIND_TOP_RISE))
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .enable(enable), .running(running),
            .last(last), .cnt(cnt), .n_act(n_act), .times(ev_time[k]),
            .fire(fire[k]), .ptr(ptr[k]), .miss(miss_v[k])
        );
        mph_onehot_dec #(.WIDTH(MAX_PH), .PW(PW)) u_dec (
            .idx(ptr[k]), .oh(dec_oh[k])
        );
    end

    for (genvar p = 0; p < MAX_PH; p++) begin : g_phase
        mph_gate_latch u_latch (
            .clk(clk), .rst_n(rst_n), .enable(enable),
            .set_top(fire[KIND_TOP_RISE] && dec_oh[KIND_TOP_RISE][p]),
            .clr_top(fire[KIND_TOP_FALL] && dec_oh[KIND_TOP_FALL][p]),
            .set_bot(fire[KIND_BOT_RISE] && dec_oh[KIND_BOT_RISE][p]),
            .clr_bot(fire[KIND_BOT_FALL] && dec_oh[KIND_BOT_FALL][p]),
            .top_raw(top_raw[p]), .bot_raw(bot_raw[p])
        );
    end

    // Overlap guard: a phase whose two latches are both set drives low.
    assign top_o = top_raw & ~bot_raw;
    assign bot_o = bot_raw & ~top_raw;

    // Sticky error flags, cleared by reset or halt.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            overlap_err <= 1'b0;
            miss_err    <= 1'b0;
        end else begin
            if (|(top_raw & bot_raw)) overlap_err <= 1'b1;
            if (|miss_v)              miss_err    <= 1'b1;
        end
    end
endmodule

// File: rtl/mph_pwm_seq_chk.sv
// Module mph_pwm_seq_chk
// Assertion checker bound to mph_pwm_seq. It watches the outputs, the
// steering decode and the phase pointers on every cycle.
module mph_pwm_seq_chk #(
    parameter int MAX_PH = 4,
    parameter int PW     = $clog2(MAX_PH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    enable,
    input logic [MAX_PH-1:0]       top_o,
    input logic [MAX_PH-1:0]       bot_o,
    input logic                    overlap_err,
    input logic                    miss_err,
    input logic [3:0][MAX_PH-1:0]  dec_oh,
    input logic [3:0][PW-1:0]      ptr,
    input logic [PW-1:0]           n_act
);
    // R7: no phase ever drives both switches.
    assert_no_shoot_through_R7: assert property (@(posedge clk)
        disable iff (!rst_n) (top_o & bot_o) == '0);

    // R9: a halt clears outputs and flags one cycle later.
    assert_halt_clears_R9: assert property (@(posedge clk)
        disable iff (!rst_n) !enable |=>
        (top_o == '0 && bot_o == '0 && !overlap_err && !miss_err));

    // R7: the overlap flag holds while enabled.
    assert_overlap_sticky_R7: assert property (@(posedge clk)
        disable iff (!rst_n) (overlap_err && enable) |=> overlap_err);

    // R8: the miss flag holds while enabled.
    assert_miss_sticky_R8: assert property (@(posedge clk)
        disable iff (!rst_n) (miss_err && enable) |=> miss_err);

    for (genvar k = 0; k < 4; k++) begin : g_chk
        // R4: each steering vector selects at most one phase.
        assert_steer_onehot_R4: assert property (@(posedge clk)
            disable iff (!rst_n) $onehot0(dec_oh[k]));
        // R4: a pointer never reaches an inactive phase.
        assert_ptr_range_R4: assert property (@(posedge clk)
            disable iff (!rst_n) ptr[k] < n_act);
    end
endmodule

bind mph_pwm_seq mph_pwm_seq_chk #(.MAX_PH(MAX_PH), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .top_o(top_o),
    .bot_o(bot_o), .overlap_err(overlap_err), .miss_err(miss_err),
    .dec_oh(dec_oh), .ptr(ptr), .n_act(n_act)
);

// File: tb/tb_mph_pwm_seq.sv
// Scoreboard bench: the driver pushes the expected gate words of each
// cycle, and a monitor pops and compares them at the falling edge.
module tb_mph_pwm_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_PH = 4;
    localparam int CW = 8;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [CW-1:0] period = 8'd40;
    logic [PW-1:0] num_phases = 3'd4;
    logic [3:0][MAX_PH-1:0][CW-1:0] ev_time = '0;
    logic [MAX_PH-1:0] top_o, bot_o;
    logic overlap_err, miss_err;

    int total = 0;
    int bad = 0;
    int tr[4], tf[4], br[4], bf[4];
    logic [7:0] exp_q[$];
    string tag_q[$];

    mph_pwm_seq #(.MAX_PH(MAX_PH), .CW(CW), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
        .num_phases(num_phases), .ev_time(ev_time), .top_o(top_o),
        .bot_o(bot_o), .overlap_err(overlap_err), .miss_err(miss_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare one expected gate word per cycle.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {24'd0, bot_o, top_o}, {24'd0, e});
        end
    end

    // An event of one kind fires only if the times up to it rise.
    function automatic bit reach(input int t[4], input int n, input int p, input bit f0);
        int prev = -1;
        if (p >= n) return 1'b0;
        for (int i = 0; i <= p; i++) begin
            int v = (f0 && i == 0) ? 0 : t[i];
            if (v <= prev) return 1'b0;
            prev = v;
        end
        return 1'b1;
    endfunction

    // Expected {bot,top} at count c with n active phases.
    function automatic logic [7:0] expv(input int c, input int n);
        logic [3:0] t, b;
        for (int p = 0; p < 4; p++) begin
            int r = (p == 0) ? 0 : tr[p];
            t[p] = reach(tr, n, p, 1'b1) && reach(tf, n, p, 1'b0) && r < c && c <= tf[p];
            b[p] = reach(br, n, p, 1'b0) && reach(bf, n, p, 1'b0) && br[p] < c && c <= bf[p];
        end
        return {b & ~t, t & ~b};
    endfunction

    task automatic load_tab();
        for (int p = 0; p < 4; p++) begin
            ev_time[0][p] = CW'(tr[p]);
            ev_time[1][p] = CW'(tf[p]);
            ev_time[2][p] = CW'(br[p]);
            ev_time[3][p] = CW'(bf[p]);
        end
    endtask

    task automatic base_times();
        tr = '{99, 10, 20, 30};
        tf = '{6, 16, 26, 36};
        br = '{8, 18, 28, 38};
        bf = '{9, 19, 29, 39};
    endtask

    // Driver: run two periods with n1 then n2 active phases.
    task automatic run_sc(string tag, int n1, int n2, bit exp_ovl, bit exp_miss);
        int pd = 40;
        period = CW'(pd);
        num_phases = PW'(n1);
        load_tab();
        @(negedge clk);
        enable = 1'b1;
        @(posedge clk);
        for (int k = 0; k < 2 * pd; k++) begin
            exp_q.push_back(expv(k % pd, (k < pd) ? n1 : n2));
            tag_q.push_back(tag);
        end
        repeat (pd / 2) @(negedge clk);
        num_phases = PW'(n2);
        while (exp_q.size() != 0) @(negedge clk);
        chk({tag, " R7 overlap_err"}, {31'd0, overlap_err}, {31'd0, exp_ovl});
        chk({tag, " R8 miss_err"}, {31'd0, miss_err}, {31'd0, exp_miss});
        enable = 1'b0;
        @(posedge clk);
        for (int k = 0; k < 3; k++) begin
            exp_q.push_back(8'h00);
            tag_q.push_back("R9 halt");
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk("R9 flags cleared", {30'd0, overlap_err, miss_err}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        base_times();
        load_tab();
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {24'd0, bot_o, top_o}, 32'd0);
        chk("R1 reset flags", {30'd0, overlap_err, miss_err}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle outputs", {24'd0, bot_o, top_o}, 32'd0);

        base_times();
        run_sc("R2 R3 R4 four phases", 4, 4, 1'b0, 1'b0);
        run_sc("R5 shed to two phases", 4, 2, 1'b0, 1'b0);
        run_sc("R4 single phase", 1, 1, 1'b0, 1'b0);
        run_sc("R5 grow to three phases", 2, 3, 1'b0, 1'b0);

        base_times();
        tf[1] = 20;
        run_sc("R7 overlap guard", 4, 4, 1'b1, 1'b0);

        base_times();
        br[2] = 15;
        run_sc("R6 R8 missed event", 4, 4, 1'b0, 1'b1);

        base_times();
        run_sc("R9 restart at phase 0", 4, 4, 1'b0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule